// File: doc/BRIEF.md
# Serial Debug Command Port

This block is the serial front end of a debug controller. An external host drives a serial clock and a data-in line and receives results on a data-out line. Each transaction starts with an 8-bit command byte. The byte carries a 5-bit register index and three flags: read/write, go and exit. Most indexes are then followed by a 32-bit data phase. On a write the host shifts the word in, and the block presents it on a register-file write port. On a read the block fetches the word from the register file through a read strobe and shifts it out. The go and exit flags do not act inside the block. They come out as one-cycle strobes when the transaction completes.

The serial clock comes from outside, so it is not used as a clock. A synchronizer chain on the system clock brings in both serial lines, and an edge detector turns serial clock transitions into single-cycle events. A 5-bit bit counter tracks the command byte and the data word. The block has no ready pin. It reports completion by holding data-out low for a fixed number of system cycles. A separate debug-entry input aborts any partial transaction, clears the bit counter and answers with a shorter low pulse.

Top module: `dbgp_port`

## Requirements
- R1: After reset, sdo is high and reg_we, reg_re, clr_stb, go_stb and exit_stb are all low.
- R2: Input bits are taken at falling edges of sclk, most significant bit first. In the command byte, bits 4:0 are the register index that appears on reg_sel, bit 5 is exit, bit 6 is go, and bit 7 is read (1) or write (0).
- R3: A write command whose index carries data takes a 32-bit word, MSB first. The block then gives exactly one reg_we pulse with that word on reg_wdata and the index on reg_sel. In the same cycle sdo goes low for exactly ACK_LEN (2) system cycles.
- R4: A read command whose index carries data gives one reg_re pulse. In the next cycle sdo goes low for exactly ACK_LEN (2) cycles. After that, each rising edge of sclk puts the next bit of the fetched word on sdo, bit 31 first, and 32 falling edges end the phase.
- R5: A set go bit gives exactly one go_stb pulse, and a set exit bit gives exactly one exit_stb pulse, when the transaction completes. A clear bit gives no pulse.
- R6: Indexes 0x0C, 0x0D and 0x0E are clear actions. They carry no data phase. Right after the command byte they give one clr_stb pulse and a 2-cycle low on sdo, with no reg_we and no reg_re.
- R7: Index 0x1F selects no register. It completes right after the command byte with a 2-cycle low on sdo, and gives no reg_we, reg_re or clr_stb.
- R8: A dbg_enter pulse drives sdo low for exactly ENTRY_LEN (1) cycle, starting in the next cycle. It drops any partial command and clears the bit counter, so that the next command is framed from its first bit.
- R9: Between transactions sdo is held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, at most a third of clk |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out and acknowledge, idles high |
| dbg_enter | input | 1 | One-cycle pulse on entry into debug mode |
| reg_sel | output | 5 | Register index of the current command |
| reg_we | output | 1 | Register-file write strobe |
| reg_wdata | output | 32 | Register-file write data |
| reg_re | output | 1 | Register-file read strobe |
| reg_rdata | input | 32 | Register-file read data, valid while reg_re is high |
| clr_stb | output | 1 | Clear-action strobe, index on reg_sel |
| go_stb | output | 1 | Go request strobe |
| exit_stb | output | 1 | Exit request strobe |

## Verification
The hardest case to reach from the ports is a debug-entry pulse that arrives while the bit counter is partway through a command byte. If the counter failed to clear, the damage would only show on the following transaction. The bench sends three stray bits, pulses dbg_enter, and then runs a complete write followed by a read-back. A stale count would split the command at the wrong bit and corrupt both the index and the data. The data-less indexes are checked the same way: each one is followed directly by a real write, which shows that no data phase was opened.

// File: rtl/dbgp_pkg.sv
package dbgp_pkg;

  localparam int CMD_BITS = 8;
  localparam int SEL_W    = 5;

  typedef enum logic [2:0] {
    ST_CMD   = 3'd0,
    ST_WDATA = 3'd1,
    ST_RLOAD = 3'd2,
    ST_ACK   = 3'd3,
    ST_RDATA = 3'd4
  } dbgp_state_e;

  localparam logic [SEL_W-1:0] SEL_NONE  = 5'h1F;
  localparam logic [SEL_W-1:0] SEL_CLR_A = 5'h0C;
  localparam logic [SEL_W-1:0] SEL_CLR_B = 5'h0D;
  localparam logic [SEL_W-1:0] SEL_CLR_C = 5'h0E;

  function automatic logic sel_is_clear(input logic [SEL_W-1:0] s);
    return (s == SEL_CLR_A) || (s == SEL_CLR_B) || (s == SEL_CLR_C);
  endfunction

  function automatic logic sel_no_data(input logic [SEL_W-1:0] s);
    return (s == SEL_NONE) || sel_is_clear(s);
  endfunction

endpackage

// File: rtl/dbgp_rst_sync.sv
module dbgp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic ff1_q, ff2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff1_q <= 1'b0;
      ff2_q <= 1'b0;
    end else begin
      ff1_q <= 1'b1;
      ff2_q <= ff1_q;
    end
  end

  assign rst_n_o = ff2_q;
endmodule

// File: rtl/dbgp_edge_sync.sv
module dbgp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sclk_fall,
  output logic sclk_rise,
  output logic sdi_o
);
  logic [STAGES:0]   ck_q;
  logic [STAGES-1:0] d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q <= '0;
      d_q  <= '0;
    end else begin
      ck_q[0] <= sclk_i;
      d_q[0]  <= sdi_i;
      for (int i = 1; i <= STAGES; i++) ck_q[i] <= ck_q[i-1];
      for (int i = 1; i < STAGES; i++)  d_q[i]  <= d_q[i-1];
    end
  end

  // newest synchronized level against the one before it
  assign sclk_fall = ck_q[STAGES]   & ~ck_q[STAGES-1];
  assign sclk_rise = ~ck_q[STAGES]  &  ck_q[STAGES-1];
  assign sdi_o     = d_q[STAGES-1];
endmodule

// File: rtl/dbgp_bitcnt.sv
module dbgp_bitcnt #(
  parameter int CMD_BITS  = 8,
  parameter int DATA_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic clr,
  output logic at_cmd_last,
  output logic at_data_last
);
  localparam int W = $clog2(DATA_BITS);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (inc || clr) cnt_q <= cnt_d;
  end

  assign at_cmd_last  = (cnt_q == W'(CMD_BITS - 1));
  assign at_data_last = (cnt_q == W'(DATA_BITS - 1));
endmodule

// File: rtl/dbgp_out_shift.sv
module dbgp_out_shift #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         bit_o
);
  logic [W-1:0] sh_q;
  logic         bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      bit_q <= 1'b1;
    end else if (load) begin
      sh_q  <= din;
      bit_q <= 1'b1;
    end else if (shift) begin
      bit_q <= sh_q[W-1];
      sh_q  <= {sh_q[W-2:0], 1'b0};
    end
  end

  assign bit_o = bit_q;
endmodule

// File: rtl/dbgp_port.sv
module dbgp_port #(
  parameter int DATA_W      = 32,
  parameter int ACK_LEN     = 2,
  parameter int ENTRY_LEN   = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic              sdo,
  input  logic              dbg_enter,
  output logic [4:0]        reg_sel,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              clr_stb,
  output logic              go_stb,
  output logic              exit_stb
);
  import dbgp_pkg::*;

  localparam int ACKW = $clog2(ACK_LEN + ENTRY_LEN + 1);

  logic rst_s_n;
  logic fall, rise, sdi_s;
  logic at_cmd_last, at_data_last;
  logic cnt_inc, cnt_clr, ld, sh, obit;

  dbgp_state_e state_q, state_d, ack_nxt_q, ack_nxt_d;
  logic [ACKW-1:0]     ack_cnt_q, ack_cnt_d;
  logic [CMD_BITS-1:0] cmd_sh_q, cmd_sh_d, cmd_byte;
  logic [DATA_W-1:0]   wsh_q, wsh_d;
  logic [SEL_W-1:0]    sel_q, sel_d;
  logic go_q, go_d, ex_q, ex_d;
  logic we_q, we_d, re_q, re_d, clr_q, clr_d, gos_q, gos_d, exs_q, exs_d;

  dbgp_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_o(rst_s_n));

  dbgp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_s_n), .sclk_i(sclk), .sdi_i(sdi),
    .sclk_fall(fall), .sclk_rise(rise), .sdi_o(sdi_s)
  );

  dbgp_bitcnt #(.CMD_BITS(CMD_BITS), .DATA_BITS(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .inc(cnt_inc), .clr(cnt_clr),
    .at_cmd_last(at_cmd_last), .at_data_last(at_data_last)
  );

  dbgp_out_shift #(.W(DATA_W)) u_oshift (
    .clk(clk), .rst_n(rst_s_n), .load(ld), .shift(sh),
    .din(reg_rdata), .bit_o(obit)
  );

  assign cmd_byte = {cmd_sh_q[CMD_BITS-2:0], sdi_s};

  always_comb begin
    state_d   = state_q;
    ack_cnt_d = ack_cnt_q;
    ack_nxt_d = ack_nxt_q;
    cmd_sh_d  = cmd_sh_q;
    wsh_d     = wsh_q;
    sel_d     = sel_q;
    go_d      = go_q;
    ex_d      = ex_q;
    we_d = 1'b0; re_d = 1'b0; clr_d = 1'b0; gos_d = 1'b0; exs_d = 1'b0;
    cnt_inc = 1'b0; cnt_clr = 1'b0; ld = 1'b0; sh = 1'b0;

    unique case (state_q)
      ST_CMD: if (fall) begin
        cnt_inc  = 1'b1;
        cmd_sh_d = cmd_byte;
        if (at_cmd_last) begin
          cnt_clr = 1'b1;
          sel_d   = cmd_byte[4:0];
          go_d    = cmd_byte[6];
          ex_d    = cmd_byte[5];
          if (sel_no_data(cmd_byte[4:0])) begin
            clr_d     = sel_is_clear(cmd_byte[4:0]);
            gos_d     = cmd_byte[6];
            exs_d     = cmd_byte[5];
            state_d   = ST_ACK;
            ack_cnt_d = ACKW'(ACK_LEN - 1);
            ack_nxt_d = ST_CMD;
          end else if (cmd_byte[7]) begin
            re_d    = 1'b1;
            state_d = ST_RLOAD;
          end else begin
            state_d = ST_WDATA;
          end
        end
      end
      ST_WDATA: if (fall) begin
        cnt_inc = 1'b1;
        wsh_d   = {wsh_q[DATA_W-2:0], sdi_s};
        if (at_data_last) begin
          cnt_clr   = 1'b1;
          we_d      = 1'b1;
          gos_d     = go_q;
          exs_d     = ex_q;
          state_d   = ST_ACK;
          ack_cnt_d = ACKW'(ACK_LEN - 1);
          ack_nxt_d = ST_CMD;
        end
      end
      ST_RLOAD: begin
        ld        = 1'b1;
        state_d   = ST_ACK;
        ack_cnt_d = ACKW'(ACK_LEN - 1);
        ack_nxt_d = ST_RDATA;
      end
      ST_ACK: begin
        if (ack_cnt_q == '0) state_d = ack_nxt_q;
        else                 ack_cnt_d = ack_cnt_q - 1'b1;
      end
      ST_RDATA: begin
        sh = rise;
        if (fall) begin
          cnt_inc = 1'b1;
          if (at_data_last) begin
            cnt_clr = 1'b1;
            gos_d   = go_q;
            exs_d   = ex_q;
            state_d = ST_CMD;
          end
        end
      end
      default: state_d = ST_CMD;
    endcase

    // debug-mode entry overrides any transaction in flight
    if (dbg_enter) begin
      state_d   = ST_ACK;
      ack_cnt_d = ACKW'(ENTRY_LEN - 1);
      ack_nxt_d = ST_CMD;
      cnt_inc = 1'b0; cnt_clr = 1'b1; ld = 1'b0; sh = 1'b0;
      we_d = 1'b0; re_d = 1'b0; clr_d = 1'b0; gos_d = 1'b0; exs_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q   <= ST_CMD;
      ack_nxt_q <= ST_CMD;
      ack_cnt_q <= '0;
      cmd_sh_q  <= '0;
      wsh_q     <= '0;
      sel_q     <= '0;
      go_q      <= 1'b0;
      ex_q      <= 1'b0;
      we_q <= 1'b0; re_q <= 1'b0; clr_q <= 1'b0; gos_q <= 1'b0; exs_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      ack_nxt_q <= ack_nxt_d;
      ack_cnt_q <= ack_cnt_d;
      cmd_sh_q  <= cmd_sh_d;
      wsh_q     <= wsh_d;
      sel_q     <= sel_d;
      go_q      <= go_d;
      ex_q      <= ex_d;
      we_q <= we_d; re_q <= re_d; clr_q <= clr_d; gos_q <= gos_d; exs_q <= exs_d;
    end
  end

  assign sdo       = (state_q == ST_ACK)   ? 1'b0 :
                     (state_q == ST_RDATA) ? obit : 1'b1;
  assign reg_sel   = sel_q;
  assign reg_we    = we_q;
  assign reg_wdata = wsh_q;
  assign reg_re    = re_q;
  assign clr_stb   = clr_q;
  assign go_stb    = gos_q;
  assign exit_stb  = exs_q;
endmodule

// File: rtl/dbgp_port_chk.sv
module dbgp_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sdo,
  input logic       dbg_enter,
  input logic [4:0] reg_sel,
  input logic       reg_we,
  input logic       reg_re,
  input logic       clr_stb,
  input logic       go_stb,
  input logic       exit_stb
);
  a_r3_we_in_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> !sdo);

  a_r4_re_then_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |=> !sdo);

  a_r8_entry_ack: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> !sdo);

  a_r3_single_access: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({reg_we, reg_re, clr_stb}));

  a_r6_clr_code: assert property (@(posedge clk) disable iff (!rst_n)
    clr_stb |-> (reg_sel == 5'h0C || reg_sel == 5'h0D || reg_sel == 5'h0E));

  a_r7_no_access_nodata: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we || reg_re) |->
      !(reg_sel == 5'h1F || reg_sel == 5'h0C || reg_sel == 5'h0D || reg_sel == 5'h0E));

  a_r5_go_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    go_stb |=> !go_stb);

  a_r5_exit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    exit_stb |=> !exit_stb);
endmodule

bind dbgp_port dbgp_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo(sdo), .dbg_enter(dbg_enter),
  .reg_sel(reg_sel), .reg_we(reg_we), .reg_re(reg_re),
  .clr_stb(clr_stb), .go_stb(go_stb), .exit_stb(exit_stb)
);

// File: tb/dbgp_port_tb.sv
module dbgp_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        sdi = 1'b0;
  logic        dbg_enter = 1'b0;
  logic        sdo;
  logic [4:0]  reg_sel;
  logic        reg_we, reg_re, clr_stb, go_stb, exit_stb;
  logic [31:0] reg_wdata, reg_rdata;

  logic [31:0] rf [32];
  int checks = 0, fails = 0;
  int we_n = 0, re_n = 0, clr_n = 0, go_n = 0, ex_n = 0;
  logic [4:0]  last_wsel;
  logic [31:0] last_wdata;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dbgp_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .dbg_enter(dbg_enter), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_re(reg_re), .reg_rdata(reg_rdata),
    .clr_stb(clr_stb), .go_stb(go_stb), .exit_stb(exit_stb)
  );

  assign reg_rdata = rf[reg_sel];

  always @(negedge clk) begin
    if (reg_we) begin
      we_n++; last_wsel = reg_sel; last_wdata = reg_wdata; rf[reg_sel] = reg_wdata;
    end
    if (reg_re)   re_n++;
    if (clr_stb)  clr_n++;
    if (go_stb)   go_n++;
    if (exit_stb) ex_n++;
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdi = b;
    wait_cyc(2);
    sclk = 1'b1;
    wait_cyc(4);
    sclk = 1'b0;
    wait_cyc(1);
  endtask

  task automatic send_cmd(input logic [7:0] c);
    for (int i = 7; i >= 0; i--) send_bit(c[i]);
  endtask

  task automatic send_word(input logic [31:0] w);
    for (int i = 31; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic recv_word(output logic [31:0] w);
    for (int i = 31; i >= 0; i--) begin
      wait_cyc(2);
      sclk = 1'b1;
      wait_cyc(4);
      w[i] = sdo;
      sclk = 1'b0;
      wait_cyc(1);
    end
  endtask

  task automatic measure_low(output int n);
    int w = 0;
    n = 0;
    while (sdo !== 1'b0 && w < 40) begin @(negedge clk); w++; end
    while (sdo === 1'b0 && n < 40) begin n++; @(negedge clk); end
  endtask

  task automatic t_reset();
    wait_cyc(6);
    chk(sdo === 1'b1, "R1 sdo after reset", 32'(sdo), 32'd1);
    chk((we_n + re_n + clr_n + go_n + ex_n) == 0, "R1 strobes after reset",
        32'(we_n + re_n + clr_n + go_n + ex_n), 32'd0);
  endtask

  task automatic t_write(input logic [4:0] s, input logic [31:0] d, input bit g, input bit e);
    int we0 = we_n, go0 = go_n, ex0 = ex_n, len;
    send_cmd({1'b0, g, e, s});
    send_word(d);
    measure_low(len);
    chk(len == 2, "R3 write ack length", 32'(len), 32'd2);
    chk(we_n == we0 + 1, "R3 one write strobe", 32'(we_n - we0), 32'd1);
    chk(last_wsel == s, "R2 write index", 32'(last_wsel), 32'(s));
    chk(last_wdata == d, "R3 write data", last_wdata, d);
    chk(go_n - go0 == int'(g), "R5 go strobe on write", 32'(go_n - go0), 32'(g));
    chk(ex_n - ex0 == int'(e), "R5 exit strobe on write", 32'(ex_n - ex0), 32'(e));
    wait_cyc(3);
    chk(sdo === 1'b1, "R9 idle high after write", 32'(sdo), 32'd1);
  endtask

  task automatic t_read(input logic [4:0] s, input logic [31:0] exp, input bit g, input bit e);
    int re0 = re_n, go0 = go_n, ex0 = ex_n, len;
    logic [31:0] got;
    send_cmd({1'b1, g, e, s});
    measure_low(len);
    chk(len == 2, "R4 read ack length", 32'(len), 32'd2);
    chk(re_n == re0 + 1, "R4 one read strobe", 32'(re_n - re0), 32'd1);
    recv_word(got);
    chk(got == exp, "R4 read data", got, exp);
    wait_cyc(3);
    chk(go_n - go0 == int'(g), "R5 go strobe on read", 32'(go_n - go0), 32'(g));
    chk(ex_n - ex0 == int'(e), "R5 exit strobe on read", 32'(ex_n - ex0), 32'(e));
    chk(sdo === 1'b1, "R9 idle high after read", 32'(sdo), 32'd1);
  endtask

  task automatic t_nodata(input logic [4:0] s, input bit g, input bit e, input bit is_clr, input string req);
    int we0 = we_n, re0 = re_n, clr0 = clr_n, go0 = go_n, ex0 = ex_n, len;
    send_cmd({1'b0, g, e, s});
    measure_low(len);
    chk(len == 2, {req, " ack after byte"}, 32'(len), 32'd2);
    wait_cyc(2);
    chk(clr_n - clr0 == int'(is_clr), {req, " clear strobe"}, 32'(clr_n - clr0), 32'(is_clr));
    chk((we_n - we0) + (re_n - re0) == 0, {req, " no register access"},
        32'((we_n - we0) + (re_n - re0)), 32'd0);
    chk(go_n - go0 == int'(g), {req, " go strobe"}, 32'(go_n - go0), 32'(g));
    chk(ex_n - ex0 == int'(e), {req, " exit strobe"}, 32'(ex_n - ex0), 32'(e));
  endtask

  task automatic t_entry(input int stray);
    int len, we0 = we_n;
    for (int i = 0; i < stray; i++) send_bit(i[0]);
    dbg_enter = 1'b1;
    @(negedge clk);
    dbg_enter = 1'b0;
    measure_low(len);
    chk(len == 1, "R8 entry ack length", 32'(len), 32'd1);
    chk(we_n == we0, "R8 no write from partial command", 32'(we_n - we0), 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rf[i] = 32'h0;
    wait_cyc(3);
    rst_n = 1'b1;
    t_reset();
    t_write(5'd3, 32'hA5A5_1234, 1'b0, 1'b0);
    t_read (5'd3, 32'hA5A5_1234, 1'b0, 1'b0);
    t_write(5'd0, 32'hFFFF_FFFF, 1'b1, 1'b0);
    t_write(5'd17, 32'h0000_0001, 1'b0, 1'b1);
    t_read (5'd17, 32'h0000_0001, 1'b1, 1'b0);
    t_read (5'd0, 32'hFFFF_FFFF, 1'b0, 1'b1);
    t_nodata(5'h0C, 1'b0, 1'b0, 1'b1, "R6 clear 0C");
    t_nodata(5'h0D, 1'b1, 1'b0, 1'b1, "R6 clear 0D");
    t_nodata(5'h0E, 1'b0, 1'b1, 1'b1, "R6 clear 0E");
    t_write(5'd9, 32'h1357_9BDF, 1'b0, 1'b0);   // R6: framed right after clear
    t_nodata(5'h1F, 1'b1, 1'b1, 1'b0, "R7 no register");
    t_write(5'd1, 32'h8000_0000, 1'b0, 1'b0);   // R7: framed right after no-select
    t_entry(3);
    t_write(5'd5, 32'hDEAD_BEEF, 1'b0, 1'b0);   // R8: counter cleared by entry
    t_read (5'd5, 32'hDEAD_BEEF, 1'b0, 1'b0);
    t_entry(0);
    t_read (5'd9, 32'h1357_9BDF, 1'b0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule